// File: doc/BRIEF.md
# Dithered-Period PWM Timing Generator

This block sets the switching rhythm of a fixed-frequency current-mode converter. It divides a fast logic clock into switching cycles and emits a start pulse at the beginning of each one. A drive signal is raised at that start. The drive is lowered either when an external current-sense comparator reports a trip or when the duty cutoff point is reached, whichever comes first. For a short window after each rising edge of the drive, the comparator input is masked. This leading-edge blanking keeps switching spikes from ending the pulse early.

The cycle length is not constant. A triangular deviation walks up and down by one clock per step around the nominal length, reaching about ±7.5 % of nominal. One full up-and-down sweep takes a configurable time of a few milliseconds, which spreads the spectral energy of the switching edges. At each cycle start, the block latches the cycle length and a duty cutoff at 80 % of that length. The duty limit and a normalized compensation-ramp code therefore follow the dithered period, and no cycle is cut short. Deasserting the enable lowers the drive at once. On re-enable, a fresh cycle starts from count zero.

Top module: `jitter_pwm_gate`

## Requirements
- R1: While reset is held, and after reset with the enable low, every output is 0.
- R2: The nominal cycle length is NOM = CLK_MHZ*1000/FSW_KHZ clocks. Each cycle lasts NOM+d clocks, where d is the deviation latched at that cycle's start. d stays within ±J, with J = NOM*JIT_PERMILLE/1000, and d is 0 for the first cycle after reset.
- R3: d changes only at a cycle boundary, and only at every DWELL-th boundary. DWELL = max(1, (SWEEP_US*FSW_KHZ/1000)/(4*J)). Each change is ±1. The sweep moves upward first, and turns around on reaching +J or −J.
- R4: `cyc_start_o` is high for exactly the clock at count 0 of each cycle while enabled.
- R5: The cutoff count L = P*DUTY_PCT/100 is computed from the period P of the current cycle. `drv_o` is low at every count ≥ L. `duty_cut_o` is high only at count L.
- R6: For counts below B = ceil(BLANK_NS*CLK_MHZ/1000), `blank_o` is high and a high `cs_trip_i` has no effect on `drv_o`.
- R7: `cs_trip_i` sampled high at a count ≥ B lowers `drv_o` from the next clock until the next cycle start.
- R8: While enabled and at count c < L, `ramp_o` = floor(c*(2^RW−1)/(L−1)). It therefore reaches 2^RW−1 at c = L−1, and is 0 from L to the end of the cycle.
- R9: With `en_i` low, `drv_o` is low in the same clock and the count returns to 0. The deviation state is held. The first enabled clock afterwards is a cycle start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| cs_trip_i | input | 1 | Current-sense comparator trip |
| cyc_start_o | output | 1 | One-clock pulse at each cycle start |
| duty_cut_o | output | 1 | One-clock pulse at the duty cutoff count |
| blank_o | output | 1 | Leading-edge blanking window |
| drv_o | output | 1 | Gate drive request |
| ramp_o | output | RW | Compensation ramp code |

## Verification
The bench builds the block with a 20 MHz timing clock, a 100 kHz switching rate and a 1200 µs sweep. These values give a 200-clock nominal cycle, a ±15-clock deviation, a dwell of 2 cycles per step and a 4-clock blanking window. With them, a complete triangular sweep, including both turnarounds, fits into about 130 switching cycles. The comparator trip is driven in several patterns: never, only inside the blanking window, a single pulse mid-cycle, held high throughout, and one clock before the cutoff. The enable is also dropped in the middle of some cycles.

// File: rtl/jitter_pwm_gate.sv
module jitter_pwm_gate #(
  parameter int CLK_MHZ      = 16,
  parameter int FSW_KHZ      = 65,
  parameter int JIT_PERMILLE = 75,
  parameter int SWEEP_US     = 6000,
  parameter int DUTY_PCT     = 80,
  parameter int BLANK_NS     = 180,
  parameter int RW           = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          cs_trip_i,
  output logic          cyc_start_o,
  output logic          duty_cut_o,
  output logic          blank_o,
  output logic          drv_o,
  output logic [RW-1:0] ramp_o
);
  localparam int NOM_PER   = CLK_MHZ * 1000 / FSW_KHZ;
  localparam int JIT_MAX   = NOM_PER * JIT_PERMILLE / 1000;
  localparam int SWEEP_CYC = SWEEP_US * FSW_KHZ / 1000;
  localparam int DWELL     = (SWEEP_CYC / (4 * JIT_MAX) > 0) ? SWEEP_CYC / (4 * JIT_MAX) : 1;
  localparam int BLANK_CYC = (BLANK_NS * CLK_MHZ + 999) / 1000;
  localparam int CW        = $clog2(NOM_PER + JIT_MAX + 1);
  localparam int DW        = $clog2(DWELL + 1);
  localparam int RMAX      = 2**RW - 1;
  localparam int LIM0      = NOM_PER * DUTY_PCT / 100;
  localparam logic signed [CW:0] JHI = (CW+1)'(JIT_MAX);
  localparam logic signed [CW:0] JLO = -(CW+1)'(JIT_MAX);
  localparam logic signed [CW:0] ONE = (CW+1)'(1);

  logic [CW-1:0]        cnt_q, per_q, lim_q, per_n, lim_n;
  logic signed [CW:0]   dev_q, dev_n;
  logic                 up_q, up_n, trip_q;
  logic [DW-1:0]        dw_q, dw_n;
  logic signed [CW+1:0] sum;
  logic [CW+7:0]        prod;
  logic [CW+RW-1:0]     num, den;
  logic                 wrap;

  assign wrap = en_i && (cnt_q == per_q - 1'b1);
  assign dw_n = (dw_q == DW'(DWELL - 1)) ? '0 : dw_q + 1'b1;

  always_comb begin
    dev_n = dev_q;
    up_n  = up_q;
    if (dw_q == DW'(DWELL - 1)) begin
      if (up_q) begin
        if (dev_q >= JHI) begin up_n = 1'b0; dev_n = dev_q - ONE; end
        else dev_n = dev_q + ONE;
      end else begin
        if (dev_q <= JLO) begin up_n = 1'b1; dev_n = dev_q + ONE; end
        else dev_n = dev_q - ONE;
      end
    end
  end

  assign sum   = (CW+2)'(NOM_PER) + (CW+2)'(dev_n);
  assign per_n = sum[CW-1:0];
  assign prod  = (CW+8)'(per_n) * (CW+8)'(DUTY_PCT);
  assign lim_n = CW'(prod / (CW+8)'(100));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      per_q  <= CW'(NOM_PER);
      lim_q  <= CW'(LIM0);
      dev_q  <= '0;
      up_q   <= 1'b1;
      dw_q   <= '0;
      trip_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      trip_q <= 1'b0;
      per_q  <= per_n;
      lim_q  <= lim_n;
      dev_q  <= dev_n;
      up_q   <= up_n;
      dw_q   <= dw_n;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cs_trip_i && !blank_o) trip_q <= 1'b1;
    end
  end

  assign cyc_start_o = en_i && (cnt_q == '0);
  assign blank_o     = en_i && (cnt_q < CW'(BLANK_CYC));
  assign duty_cut_o  = en_i && (cnt_q == lim_q);
  assign drv_o       = en_i && !trip_q && (cnt_q < lim_q);

  assign num    = (CW+RW)'(cnt_q) * (CW+RW)'(RMAX);
  assign den    = (CW+RW)'(lim_q) - (CW+RW)'(1);
  assign ramp_o = (en_i && cnt_q < lim_q) ? RW'(num / den) : '0;
endmodule

// File: rtl/jitter_pwm_gate_chk.sv
module jitter_pwm_gate_chk #(
  parameter int PW = 8,
  parameter int LO = 1,
  parameter int HI = 255
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          en_i,
  input logic          cs_trip_i,
  input logic          cyc_start_o,
  input logic          duty_cut_o,
  input logic          blank_o,
  input logic          drv_o,
  input logic [PW-1:0] per
);
  // R2
  period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(per) >= LO) && (int'(per) <= HI));
  // R4
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_start_o |=> !cyc_start_o);
  // R5
  cut_holds_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    duty_cut_o |=> !drv_o);
  // R6
  blank_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> drv_o);
  // R7
  trip_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && drv_o && !blank_o && cs_trip_i) |=> (!drv_o || cyc_start_o));
  // R9
  disable_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !drv_o);
endmodule

bind jitter_pwm_gate jitter_pwm_gate_chk #(
  .PW(CW), .LO(NOM_PER - JIT_MAX), .HI(NOM_PER + JIT_MAX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cs_trip_i(cs_trip_i),
  .cyc_start_o(cyc_start_o), .duty_cut_o(duty_cut_o), .blank_o(blank_o),
  .drv_o(drv_o), .per(per_q)
);

// File: tb/sim_jitter_pwm_gate.sv
module sim_jitter_pwm_gate;
  localparam int CLK_MHZ = 20, FSW_KHZ = 100, JPM = 75, SWP = 1200, DUTY = 80, BNS = 180, RW = 8;
  localparam int NOM   = CLK_MHZ * 1000 / FSW_KHZ;
  localparam int J     = NOM * JPM / 1000;
  localparam int SCYC  = SWP * FSW_KHZ / 1000;
  localparam int DWELL = (SCYC / (4 * J) > 0) ? SCYC / (4 * J) : 1;
  localparam int B     = (BNS * CLK_MHZ + 999) / 1000;
  localparam int RMAX  = 2**RW - 1;

  logic clk = 0, rst_ni = 0, en_i = 0, cs_trip_i = 0;
  logic cyc_start_o, duty_cut_o, blank_o, drv_o;
  logic [RW-1:0] ramp_o;

  always #2 clk = ~clk;

  jitter_pwm_gate #(.CLK_MHZ(CLK_MHZ), .FSW_KHZ(FSW_KHZ), .JIT_PERMILLE(JPM),
    .SWEEP_US(SWP), .DUTY_PCT(DUTY), .BLANK_NS(BNS), .RW(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .cs_trip_i(cs_trip_i),
    .cyc_start_o(cyc_start_o), .duty_cut_o(duty_cut_o), .blank_o(blank_o),
    .drv_o(drv_o), .ramp_o(ramp_o));

  int checks = 0, fails = 0;
  int m_cnt, m_per, m_lim, m_dev, m_dw, m_cycles;
  bit m_up, m_trip, finished = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_cnt = 0; m_per = NOM; m_lim = NOM * DUTY / 100;
      m_dev = 0; m_up = 1; m_dw = 0; m_trip = 0; m_cycles = 0;
    end else if (!en_i) begin
      m_cnt = 0; m_trip = 0;
    end else if (m_cnt == m_per - 1) begin
      if (m_dw == DWELL - 1) begin
        m_dw = 0;
        if (m_up) begin
          if (m_dev == J) begin m_up = 0; m_dev--; end else m_dev++;
        end else begin
          if (m_dev == -J) begin m_up = 1; m_dev++; end else m_dev--;
        end
      end else m_dw++;
      m_per = NOM + m_dev;
      m_lim = m_per * DUTY / 100;
      m_cnt = 0; m_trip = 0; m_cycles++;
    end else begin
      if (cs_trip_i && m_cnt >= B) m_trip = 1;
      m_cnt++;
    end
  end

  task automatic compare_all();
    int en = int'(en_i);
    chk("R4 cyc_start", int'(cyc_start_o), en & int'(m_cnt == 0));
    chk("R6 blank", int'(blank_o), en & int'(m_cnt < B));
    chk("R5 duty_cut", int'(duty_cut_o), en & int'(m_cnt == m_lim));
    chk("R7 drv", int'(drv_o), en & int'(!m_trip) & int'(m_cnt < m_lim));
    chk("R8 ramp", int'(ramp_o), (en && m_cnt < m_lim) ? m_cnt * RMAX / (m_lim - 1) : 0);
  endtask

  initial begin
    int tick = 0, prev = 0, pmin = 1 << 30, pmax = 0, first_per = -1, dis_left = 0;
    bit have_prev = 0, gap = 0, dis_done = 0;
    int last_cyc = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset drv", int'(drv_o), 0);
    chk("R1 reset start", int'(cyc_start_o), 0);
    chk("R1 reset ramp", int'(ramp_o), 0);
    @(negedge clk); rst_ni = 1;
    repeat (3) begin
      @(negedge clk); #1;
      chk("R1 idle drv", int'(drv_o), 0);
      chk("R1 idle blank", int'(blank_o), 0);
      chk("R1 idle cut", int'(duty_cut_o), 0);
    end
    while (m_cycles < 130) begin
      @(negedge clk);
      tick++;
      if (m_cycles != last_cyc) begin dis_done = 0; last_cyc = m_cycles; end
      if (dis_left > 0) begin en_i = 0; dis_left--; end
      else if (m_cycles % 7 == 3 && m_cnt == 90 && !dis_done) begin
        en_i = 0; dis_left = 36; dis_done = 1;
      end else en_i = 1;
      case (m_cycles % 4)
        0: cs_trip_i = (m_cycles % 8 == 4) ? (m_cnt == m_lim - 1) : 1'b0;
        1: cs_trip_i = (m_cnt < B);
        2: cs_trip_i = (m_cnt == 60);
        default: cs_trip_i = 1'b1;
      endcase
      #1;
      compare_all();
      if (en_i && m_cnt == m_lim - 1 && m_cycles % 4 == 0 && m_cycles % 8 != 4)
        chk("R8 ramp peak", int'(ramp_o), RMAX);
      if (!en_i) begin gap = 1; chk("R9 drv off", int'(drv_o), 0); end
      if (cyc_start_o) begin
        if (have_prev && !gap) begin
          if (first_per < 0) begin
            first_per = tick - prev;
            chk("R2 first period", first_per, NOM);
          end
          if (tick - prev < pmin) pmin = tick - prev;
          if (tick - prev > pmax) pmax = tick - prev;
        end
        prev = tick; have_prev = 1; gap = 0;
      end
    end
    chk("R2 shortest period", pmin, NOM - J);
    chk("R3 longest period", pmax, NOM + J);
    finished = 1;
    wrap_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      wrap_up();
    end
  end
endmodule